// File: doc/BRIEF.md
# Rotating Register Window Controller

This block keeps the bookkeeping for a register file that software sees through a sliding 16-entry window. The physical file holds `PHYS_REGS` registers (a power of two, at least 16), grouped into units of four. A window base pointer, counted in units, picks where the window starts, and a bitmap with one bit per unit records which units begin a live call frame. The block turns any logical register number into a physical index and applies the window rules for call entry, windowed return, window-overflow probing, the stack-pointer move, explicit rotation, and direct base loads.

The surrounding pipeline presents one operation per cycle with its operands: register number, immediate, register value, program counter, and the window-enable, exception-mode and call-increment fields of the status register. One clock later the block reports a single outcome. That outcome is a register-file write, a return target, an exception request with its kind, the old base and the faulting PC, or an illegal-instruction flag. The block does not own the status register. The pipeline stores the reported old base and sets exception mode itself, and it runs the spill and fill handlers.

Top module: `regwin_ctrl`

## Requirements
- R1: While reset is held and after it is released, `wbase` is 0 and `wstart` has only bit 0 set; `wr_en`, `exc_valid`, `illegal` and `ret_valid` are 0.
- R2: `lk_phys` equals (4*`wbase` + `lk_log`) modulo `PHYS_REGS`, combinationally.
- R3: An entry (op_code 1) whose `op_reg` exceeds 3, or issued when the status check fails, sets `illegal` for one cycle. The status check passes only when `ps_woe`=1 and `ps_excm`=0. Base and bitmap stay unchanged.
- R4: A legal entry writes `op_val` minus 8*`op_imm` to the physical register that logical register 4*`ps_callinc`+`op_reg` maps to under the old base. It also advances the base by `ps_callinc` and sets the bitmap bit of the new base.
- R5: A window check (op_code 3) of depth w=`op_reg[1:0]` does nothing when the status check fails or when no bitmap bit is set at base+1 through base+w.
- R6: Otherwise the window check takes the nearest such unit at base+n. It raises an overflow with kind 1 (4 registers) if bit m+1 is set, kind 2 (8) if bit m+2 is set, and kind 3 (12) otherwise, where m=base+n. It reports the old base and `op_pc`, and rotates the base forward by n.
- R7: A return (op_code 2) takes n=`op_val[31:30]`. The nearest set bit at base-1, base-2 or base-3 gives m=1, 2 or 3 (0 if none). The return is illegal when n=0, when m is nonzero and differs from n, or when the status check fails. An illegal return leaves base and bitmap unchanged.
- R8: A legal return moves the base back by n. If the new base's bit is set, it clears the old base's bit, pulses `ret_valid`, and gives `ret_pc` = {`op_pc[31:30]`, `op_val[29:0]`}.
- R9: If the new base's bit is clear, the return raises an underflow of kind 4, 5 or 6 for n = 1, 2 or 3, with the old base and `op_pc`. The base still moves back and the bitmap is unchanged.
- R10: A stack-pointer move (op_code 5) raises kind 7 when none of the bits at base-1, base-2 and base-3 is set. Otherwise it has no effect.
- R11: A rotate (op_code 4) adds the signed 4-bit `op_imm[3:0]` to the base, modulo the unit count.
- R12: Loading the base (op_code 6) or restoring it from the saved old-base value (op_code 7) sets the base to `op_val` modulo the unit count.
- R13: Each operation produces at most one of write, exception, illegal and return, and a faulting operation never writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation select (see requirements) |
| op_reg | input | 4 | Register operand / check depth |
| op_imm | input | 12 | Frame size for entry, rotate amount in bits 3:0 |
| op_val | input | XLEN (32) | Stack register, link register, or new base |
| op_pc | input | XLEN (32) | PC of the operation |
| ps_woe | input | 1 | Window-overflow enable from status |
| ps_excm | input | 1 | Exception mode from status |
| ps_callinc | input | 2 | Call increment from status |
| lk_log | input | 4 | Logical register to translate |
| lk_phys | output | PW (6) | Physical index of `lk_log` |
| wr_en | output | 1 | Register-file write request |
| wr_phys | output | PW (6) | Write target |
| wr_data | output | XLEN (32) | Write value |
| exc_valid | output | 1 | Exception request |
| exc_kind | output | 3 | Exception kind code |
| exc_owb | output | UW (4) | Base before the operation |
| exc_pc | output | XLEN (32) | PC to save |
| illegal | output | 1 | Illegal-instruction flag |
| ret_valid | output | 1 | Return completed |
| ret_pc | output | XLEN (32) | Return target |
| wbase | output | UW (4) | Current window base |
| wstart | output | UNITS (16) | Live-frame bitmap |

## Verification
The hardest outcomes to reach are the 8- and 12-register overflow kinds and a mismatched return. They need a bitmap with gaps at specific distances from the base, and the ports cannot write the bitmap directly. The stimulus builds those gaps from legal operations. Entries set bits, successful returns clear them again, and base loads place the window where the probe sees the wanted pattern. An independent model of base and bitmap tracks every step, so the expected kind follows from the requirements alone.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_ENTRY   = 3'd1,
        OP_RETURN  = 3'd2,
        OP_WCHECK  = 3'd3,
        OP_ROTATE  = 3'd4,
        OP_MOVSP   = 3'd5,
        OP_SETBASE = 3'd6,
        OP_RESTORE = 3'd7
    } win_op_e;

    typedef enum logic [2:0] {
        EXK_NONE   = 3'd0,
        EXK_OVF4   = 3'd1,
        EXK_OVF8   = 3'd2,
        EXK_OVF12  = 3'd3,
        EXK_UNF4   = 3'd4,
        EXK_UNF8   = 3'd5,
        EXK_UNF12  = 3'd6,
        EXK_ALLOCA = 3'd7
    } win_exc_e;

    typedef struct packed {
        logic     wr;
        logic     exc;
        logic     ill;
        logic     ret;
        win_exc_e kind;
    } win_outcome_t;

    function automatic win_exc_e underflow_kind(input logic [1:0] n);
        case (n)
            2'd1:    return EXK_UNF4;
            2'd2:    return EXK_UNF8;
            default: return EXK_UNF12;
        endcase
    endfunction

    function automatic logic status_ok(input logic woe, input logic excm);
        return woe & ~excm;
    endfunction

endpackage

// File: rtl/regwin_remap.sv
module regwin_remap #(
    parameter int UW = 4,
    parameter int PW = 6
) (
    input  logic [UW-1:0] base,
    input  logic [3:0]    lreg,
    output logic [PW-1:0] preg
);
    // PW equals UW+2, so the sum wraps at the physical register count.
    assign preg = {base, 2'b00} + PW'(lreg);
endmodule

// File: rtl/regwin_probe.sv
module regwin_probe
    import regwin_pkg::*;
#(
    parameter int UNITS = 16,
    parameter int UW    = 4
) (
    input  logic [UW-1:0]    base,
    input  logic [UNITS-1:0] start,
    input  logic [1:0]       depth,
    output logic             fwd_hit,
    output logic [1:0]       fwd_step,
    output win_exc_e         fwd_kind,
    output logic [1:0]       back_step
);
    // Bitmap seen relative to the base: rel[i] is the bit of unit base+i.
    logic [UNITS-1:0] rel;

    for (genvar i = 0; i < UNITS; i++) begin : g_rel
        assign rel[i] = start[base + UW'(i)];
    end

    logic [UW-1:0] moff;

    always_comb begin
        fwd_hit  = 1'b0;
        fwd_step = 2'd0;
        for (int k = 3; k >= 1; k--) begin
            if (2'(k) <= depth && rel[UW'(k)]) begin
                fwd_hit  = 1'b1;
                fwd_step = 2'(k);
            end
        end
        moff = UW'(fwd_step);
        if (rel[moff + UW'(1)])
            fwd_kind = EXK_OVF4;
        else if (rel[moff + UW'(2)])
            fwd_kind = EXK_OVF8;
        else
            fwd_kind = EXK_OVF12;
    end

    always_comb begin
        if (rel[UNITS-1])
            back_step = 2'd1;
        else if (rel[UNITS-2])
            back_step = 2'd2;
        else if (rel[UNITS-3])
            back_step = 2'd3;
        else
            back_step = 2'd0;
    end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
    import regwin_pkg::*;
#(
    parameter int PHYS_REGS = 64,
    parameter int XLEN      = 32,
    localparam int UNITS    = PHYS_REGS / 4,
    localparam int UW       = $clog2(UNITS),
    localparam int PW       = UW + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [3:0]       op_reg,
    input  logic [11:0]      op_imm,
    input  logic [XLEN-1:0]  op_val,
    input  logic [XLEN-1:0]  op_pc,
    input  logic             ps_woe,
    input  logic             ps_excm,
    input  logic [1:0]       ps_callinc,
    input  logic [3:0]       lk_log,
    output logic [PW-1:0]    lk_phys,
    output logic             wr_en,
    output logic [PW-1:0]    wr_phys,
    output logic [XLEN-1:0]  wr_data,
    output logic             exc_valid,
    output logic [2:0]       exc_kind,
    output logic [UW-1:0]    exc_owb,
    output logic [XLEN-1:0]  exc_pc,
    output logic             illegal,
    output logic             ret_valid,
    output logic [XLEN-1:0]  ret_pc,
    output logic [UW-1:0]    wbase,
    output logic [UNITS-1:0] wstart
);
    logic [UW-1:0]    base_q, base_d;
    logic [UNITS-1:0] start_q, start_d;
    win_outcome_t     out_q, out_d;
    logic [PW-1:0]    wphys_q;
    logic [XLEN-1:0]  wdata_q, wdata_d, epc_q, rpc_q, rpc_d;
    logic [UW-1:0]    owb_q;

    win_op_e          op;
    logic             ps_ok;
    logic [1:0]       ret_n;
    logic [UW-1:0]    base_call, base_back, base_ovf, rot_amt;
    logic [PW-1:0]    wr_tgt;
    logic             fwd_hit;
    logic [1:0]       fwd_step, back_step;
    win_exc_e         fwd_kind;

    assign op        = win_op_e'(op_code);
    assign ps_ok     = status_ok(ps_woe, ps_excm);
    assign ret_n     = op_val[XLEN-1 -: 2];
    assign base_call = base_q + UW'(ps_callinc);
    assign base_back = base_q - UW'(ret_n);
    assign base_ovf  = base_q + UW'(fwd_step);
    assign rot_amt   = UW'({{(XLEN-4){op_imm[3]}}, op_imm[3:0]});

    regwin_remap #(.UW(UW), .PW(PW)) u_look (
        .base (base_q),
        .lreg (lk_log),
        .preg (lk_phys)
    );

    regwin_remap #(.UW(UW), .PW(PW)) u_wtgt (
        .base (base_q),
        .lreg ({ps_callinc, op_reg[1:0]}),
        .preg (wr_tgt)
    );

    regwin_probe #(.UNITS(UNITS), .UW(UW)) u_probe (
        .base      (base_q),
        .start     (start_q),
        .depth     (op_reg[1:0]),
        .fwd_hit   (fwd_hit),
        .fwd_step  (fwd_step),
        .fwd_kind  (fwd_kind),
        .back_step (back_step)
    );

    always_comb begin
        base_d  = base_q;
        start_d = start_q;
        out_d   = '{wr: 1'b0, exc: 1'b0, ill: 1'b0, ret: 1'b0, kind: EXK_NONE};
        wdata_d = op_val - (XLEN'(op_imm) << 3);
        rpc_d   = {op_pc[XLEN-1 -: 2], op_val[XLEN-3:0]};
        if (op_valid) begin
            case (op)
                OP_ENTRY: begin
                    if (op_reg[3:2] != 2'b00 || !ps_ok) begin
                        out_d.ill = 1'b1;
                    end else begin
                        out_d.wr           = 1'b1;
                        base_d             = base_call;
                        start_d[base_call] = 1'b1;
                    end
                end
                OP_RETURN: begin
                    if (ret_n == 2'd0 || (back_step != 2'd0 && back_step != ret_n) || !ps_ok) begin
                        out_d.ill = 1'b1;
                    end else begin
                        base_d = base_back;
                        if (start_q[base_back]) begin
                            start_d[base_q] = 1'b0;
                            out_d.ret       = 1'b1;
                        end else begin
                            out_d.exc  = 1'b1;
                            out_d.kind = underflow_kind(ret_n);
                        end
                    end
                end
                OP_WCHECK: begin
                    if (ps_ok && fwd_hit) begin
                        out_d.exc  = 1'b1;
                        out_d.kind = fwd_kind;
                        base_d     = base_ovf;
                    end
                end
                OP_ROTATE: base_d = base_q + rot_amt;
                OP_MOVSP: begin
                    if (back_step == 2'd0) begin
                        out_d.exc  = 1'b1;
                        out_d.kind = EXK_ALLOCA;
                    end
                end
                OP_SETBASE, OP_RESTORE: base_d = op_val[UW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            start_q <= UNITS'(1);
            out_q   <= '{wr: 1'b0, exc: 1'b0, ill: 1'b0, ret: 1'b0, kind: EXK_NONE};
            wphys_q <= '0;
            wdata_q <= '0;
            epc_q   <= '0;
            rpc_q   <= '0;
            owb_q   <= '0;
        end else begin
            base_q  <= base_d;
            start_q <= start_d;
            out_q   <= out_d;
            if (out_d.wr) begin
                wphys_q <= wr_tgt;
                wdata_q <= wdata_d;
            end
            if (out_d.exc || out_d.ill) begin
                epc_q <= op_pc;
                owb_q <= base_q;
            end
            if (out_d.ret)
                rpc_q <= rpc_d;
        end
    end

    assign wbase     = base_q;
    assign wstart    = start_q;
    assign wr_en     = out_q.wr;
    assign wr_phys   = wphys_q;
    assign wr_data   = wdata_q;
    assign exc_valid = out_q.exc;
    assign exc_kind  = out_q.kind;
    assign exc_owb   = owb_q;
    assign exc_pc    = epc_q;
    assign illegal   = out_q.ill;
    assign ret_valid = out_q.ret;
    assign ret_pc    = rpc_q;

    // R3, R7: a rejected operation leaves the window state alone
    p_illegal_holds_r3: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (wbase == $past(wbase) && wstart == $past(wstart)));

    // R4: after an entry the new base is marked live
    p_entry_live_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wstart[wbase]);

    // R6: an overflow always moves the window forward
    p_overflow_moves_r6: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && exc_kind inside {3'd1, 3'd2, 3'd3}) |-> wbase != $past(wbase));

    // R8: a completed return releases the frame it left
    p_return_clears_r8: assert property (@(posedge clk) disable iff (rst)
        ret_valid |-> !wstart[$past(wbase)]);

    // R9: an underflow keeps the bitmap
    p_underflow_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && exc_kind inside {3'd4, 3'd5, 3'd6}) |-> wstart == $past(wstart));

    // R10: an alloca fault does not rotate
    p_alloca_still_r10: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && exc_kind == 3'd7) |-> wbase == $past(wbase));

    // R13: at most one outcome per operation
    p_single_outcome_r13: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, exc_valid, illegal, ret_valid}));

    // R1: outcomes only follow an operation
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(op_valid) |-> !(wr_en || exc_valid || illegal || ret_valid));
endmodule

// File: tb/regwin_ctrl_test.sv
module regwin_ctrl_test;
    localparam int U = 16;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [3:0]  op_reg = '0;
    logic [11:0] op_imm = '0;
    logic [31:0] op_val = '0, op_pc = '0;
    logic        ps_woe = 1'b0, ps_excm = 1'b0;
    logic [1:0]  ps_callinc = '0;
    logic [3:0]  lk_log = '0;
    logic [5:0]  lk_phys, wr_phys;
    logic        wr_en, exc_valid, illegal, ret_valid;
    logic [31:0] wr_data, exc_pc, ret_pc;
    logic [2:0]  exc_kind;
    logic [3:0]  exc_owb, wbase;
    logic [15:0] wstart;

    regwin_ctrl uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_reg(op_reg),
        .op_imm(op_imm), .op_val(op_val), .op_pc(op_pc), .ps_woe(ps_woe), .ps_excm(ps_excm),
        .ps_callinc(ps_callinc), .lk_log(lk_log), .lk_phys(lk_phys), .wr_en(wr_en),
        .wr_phys(wr_phys), .wr_data(wr_data), .exc_valid(exc_valid), .exc_kind(exc_kind),
        .exc_owb(exc_owb), .exc_pc(exc_pc), .illegal(illegal), .ret_valid(ret_valid),
        .ret_pc(ret_pc), .wbase(wbase), .wstart(wstart)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic        wr, exc, ill, ret;
        logic [5:0]  wphys;
        logic [31:0] wdata, epc, rpc;
        logic [2:0]  kind;
        logic [3:0]  owb, base;
        logic [15:0] start;
        string       tag;
    } exp_t;

    exp_t q[$];
    int errors = 0, checks = 0;
    int mb = 0;
    logic [15:0] ms = 16'h0001;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int wrapu(input int u);
        return ((u % U) + U) % U;
    endfunction

    function automatic bit live(input int u);
        return ms[wrapu(u)];
    endfunction

    task automatic run_op(input int code, input int r, input int imm, input logic [31:0] val,
                          input logic [31:0] pc, input bit woe, input bit excm, input int ci,
                          input string tag);
        exp_t e;
        bit ok = woe && !excm;
        int n, m;
        e = '{wr: 0, exc: 0, ill: 0, ret: 0, wphys: 0, wdata: 0, epc: pc, rpc: 0,
              kind: 0, owb: 4'(mb), base: 0, start: 0, tag: tag};
        case (code)
            1: if (r > 3 || !ok) e.ill = 1;
               else begin
                   e.wr = 1; e.wphys = 6'((mb * 4 + ci * 4 + r) % N);
                   e.wdata = val - 32'(imm * 8);
                   mb = wrapu(mb + ci); ms[mb] = 1'b1;
               end
            2: begin
                n = int'(val[31:30]);
                m = live(mb - 1) ? 1 : live(mb - 2) ? 2 : live(mb - 3) ? 3 : 0;
                if (n == 0 || (m != 0 && m != n) || !ok) e.ill = 1;
                else begin
                    if (live(mb - n)) begin
                        ms[mb] = 1'b0; e.ret = 1; e.rpc = {pc[31:30], val[29:0]};
                    end else begin
                        e.exc = 1; e.kind = 3'(3 + n);
                    end
                    mb = wrapu(mb - n);
                end
            end
            3: if (ok) begin
                   n = 0;
                   for (int k = (r & 3); k >= 1; k--) if (live(mb + k)) n = k;
                   if (n != 0) begin
                       m = mb + n; e.exc = 1;
                       e.kind = live(m + 1) ? 3'd1 : live(m + 2) ? 3'd2 : 3'd3;
                       mb = wrapu(m);
                   end
               end
            4: mb = wrapu(mb + ((imm & 8) != 0 ? (imm & 15) - 16 : (imm & 15)));
            5: if (!live(mb - 1) && !live(mb - 2) && !live(mb - 3)) begin
                   e.exc = 1; e.kind = 3'd7;
               end
            default: mb = int'(val & 32'd15);
        endcase
        e.base = 4'(mb); e.start = ms;
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'(code); op_reg = 4'(r); op_imm = 12'(imm);
        op_val = val; op_pc = pc; ps_woe = woe; ps_excm = excm; ps_callinc = 2'(ci);
        q.push_back(e);
    endtask

    // Monitor: results of an operation sampled at the edge appear just after it.
    always @(posedge clk) begin
        if (!rst && op_valid) begin
            exp_t e;
            #3;
            if (q.size() == 0) chk(0, "R13", "unexpected result", 0, 0);
            else begin
                e = q.pop_front();
                chk({wr_en, exc_valid, illegal, ret_valid} == {e.wr, e.exc, e.ill, e.ret},
                    e.tag, "outcome(R13)", 32'({wr_en, exc_valid, illegal, ret_valid}),
                    32'({e.wr, e.exc, e.ill, e.ret}));
                if (e.wr) begin
                    chk(wr_phys == e.wphys, e.tag, "wr_phys", 32'(wr_phys), 32'(e.wphys));
                    chk(wr_data == e.wdata, e.tag, "wr_data", wr_data, e.wdata);
                end
                if (e.exc) begin
                    chk(exc_kind == e.kind, e.tag, "exc_kind", 32'(exc_kind), 32'(e.kind));
                    chk(exc_owb == e.owb && exc_pc == e.epc, e.tag, "owb/pc",
                        {exc_owb, exc_pc[27:0]}, {e.owb, e.epc[27:0]});
                end
                if (e.ret) chk(ret_pc == e.rpc, e.tag, "ret_pc", ret_pc, e.rpc);
                chk(wbase == e.base, e.tag, "wbase", 32'(wbase), 32'(e.base));
                chk(wstart == e.start, e.tag, "wstart", 32'(wstart), 32'(e.start));
            end
        end
    end

    task automatic idle_map(input int lg, input string tag);
        @(negedge clk);
        op_valid = 1'b0; lk_log = 4'(lg);
        #1;
        chk(lk_phys == 6'((mb * 4 + lg) % N), tag, "lk_phys", 32'(lk_phys), 32'((mb * 4 + lg) % N));
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while held in reset
        chk(wbase == 0 && wstart == 16'h0001, "R1", "reset state", {wbase, wstart}, 32'h0001);
        rst = 1'b0;
        @(negedge clk);
        chk({wr_en, exc_valid, illegal, ret_valid} == 4'b0, "R1", "idle outputs",
            32'({wr_en, exc_valid, illegal, ret_valid}), 0);
        // R2: mapping at base 0
        for (int i = 0; i < 16; i += 5) idle_map(i, "R2");
        // R3: illegal entries
        run_op(1, 5, 2, 32'h100, 32'hA0, 1, 0, 1, "R3");
        run_op(1, 1, 2, 32'h100, 32'hA4, 1, 1, 1, "R3");
        run_op(1, 1, 2, 32'h100, 32'hA8, 0, 0, 1, "R3");
        // R4: legal entries
        run_op(1, 1, 4, 32'h1000, 32'hB0, 1, 0, 1, "R4");
        run_op(1, 1, 3, 32'h2000, 32'hB4, 1, 0, 2, "R4");
        idle_map(5, "R2");
        // R8: return by 2 from base 3
        run_op(2, 0, 0, 32'h8000_1234, 32'hC000_0010, 1, 0, 0, "R8");
        // R7: illegal returns
        run_op(2, 0, 0, 32'hC000_0000, 32'h20, 1, 0, 0, "R7");
        run_op(2, 0, 0, 32'h0000_0040, 32'h24, 1, 0, 0, "R7");
        run_op(2, 0, 0, 32'h4000_0040, 32'h28, 1, 1, 0, "R7");
        // R5: no live frame ahead, and disabled check
        run_op(3, 3, 0, 0, 32'h30, 1, 0, 0, "R5");
        run_op(6, 0, 0, 32'd14, 0, 1, 0, 0, "R12");
        run_op(3, 2, 0, 0, 32'h34, 1, 1, 0, "R5");
        // R6: overflow, 4-register kind
        run_op(3, 2, 0, 0, 32'h38, 1, 0, 0, "R6");
        // build gap for 8-register kind
        run_op(6, 0, 0, 32'd1, 0, 1, 0, 0, "R12");
        run_op(2, 0, 0, 32'h4000_0200, 32'h40, 1, 0, 0, "R8");
        run_op(6, 0, 0, 32'd1, 0, 1, 0, 0, "R12");
        run_op(1, 0, 1, 32'h300, 32'h44, 1, 0, 1, "R4");
        run_op(6, 0, 0, 32'd15, 0, 1, 0, 0, "R12");
        run_op(3, 1, 0, 0, 32'h48, 1, 0, 0, "R6");
        // clear bit 2, then 12-register kind
        run_op(6, 0, 0, 32'd2, 0, 1, 0, 0, "R12");
        run_op(2, 0, 0, 32'h8000_0300, 32'h4C, 1, 0, 0, "R8");
        run_op(6, 0, 0, 32'd14, 0, 1, 0, 0, "R12");
        run_op(3, 3, 0, 0, 32'h50, 1, 0, 0, "R6");
        // R9: underflows
        run_op(2, 0, 0, 32'h4000_0000, 32'h54, 1, 0, 0, "R9");
        run_op(6, 0, 0, 32'd5, 0, 1, 0, 0, "R12");
        run_op(2, 0, 0, 32'hC000_0000, 32'h58, 1, 0, 0, "R9");
        // R10: stack-pointer move
        run_op(5, 0, 0, 0, 32'h5C, 1, 0, 0, "R10");
        run_op(6, 0, 0, 32'd8, 0, 1, 0, 0, "R12");
        run_op(5, 0, 0, 0, 32'h60, 1, 0, 0, "R10");
        // R11: signed rotations with wrap
        run_op(4, 0, 13, 0, 0, 1, 0, 0, "R11");
        run_op(4, 0, 7, 0, 0, 1, 0, 0, "R11");
        run_op(4, 0, 7, 0, 0, 1, 0, 0, "R11");
        run_op(4, 0, 8, 0, 0, 1, 0, 0, "R11");
        // R12: restore with masking
        run_op(7, 0, 0, 32'h23, 0, 1, 0, 0, "R12");
        // R4 + R2: physical wrap at top of file
        run_op(6, 0, 0, 32'd15, 0, 1, 0, 0, "R12");
        run_op(1, 3, 1, 32'h50, 32'h64, 1, 0, 1, "R4");
        run_op(6, 0, 0, 32'd15, 0, 1, 0, 0, "R12");
        idle_map(10, "R2");
        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R13", "pending results", 32'(q.size()), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule